// File: doc/BRIEF.md
# Programmable Skew Clock Output Banks

This block is the digital output stage of a clock driver whose outputs can lead or lag a reference. A fast phase clock steps an internal period counter, and the counter shapes a nominal output clock of 44, 26 or 16 steps per period. One step of the fast clock is the skew time unit. The nominal clock passes through a shared tapped delay line. Each of four banks drives two identical outputs and picks a tap, a divided clock or an inverted clock. It picks from a nine-entry map that two three-level selects address.

Every select is a three-level input carried as a 2-bit code. When the test select is not LOW, the internal period generator is bypassed and the reference input feeds the delay line in its place. A stop input parks the outputs synchronously. The test select can also park single banks. Gating only changes while an output already sits at its parked level, so no output ever produces a shortened pulse. An edge-polarity input chooses whether outputs and divided clocks follow the rising or the falling reference edge.

Top module: `skew_clk_banks`

## Requirements
- R1: A three-level code reads 2'b00 as LOW, 2'b01 as MID, 2'b10 as HIGH and 2'b11 as MID. A bank whose selects are both MID (either MID code) has zero skew.
- R2: In normal mode (test select LOW) the nominal output period is 44, 26 or 16 fast-clock cycles for range select LOW, MID or HIGH. The output is high for half of that period.
- R3: Bank selects are bank_sel[4b+3:4b+2] (first select) and bank_sel[4b+1:4b] (second select) for bank b = 0..3. Setting index = 3*first + second, with LOW=0, MID=1, HIGH=2. For banks 0 and 1, index i gives a skew of (i-4) cycles. Both outputs of a bank (q[2b], q[2b+1]) are always equal.
- R4: For banks 2 and 3, index 0 divides the nominal clock by 2. Indices 1..7 give a skew of 2*(i-4) cycles.
- R5: Index 8 makes bank 2 a divide-by-4 clock and bank 3 the inverse of the zero-skew clock. Every rising edge of the divide-by-4 clock coincides with a rising edge of the divide-by-2 clock.
- R6: While out_stop is high, banks 0, 1 and 3 park LOW. Bank 2 keeps running.
- R7: When bank 3 is in inverted mode and parked, it rests at the edge_pol level.
- R8: With test select MID and out_stop high, a bank set to index 0 is parked LOW, including bank 2. Without out_stop, index 0 keeps its divide meaning.
- R9: With test select MID or HIGH, ref_in replaces the internal generator. A zero-skew output reproduces ref_in 8 fast-clock cycles later, and skews still shift it.
- R10: With edge_pol high the divided clocks change 8 cycles after a ref_in rising edge. With edge_pol low they change 8 cycles after a falling edge.
- R11: Parking and releasing never produce a high pulse shorter than the nominal high time.
- R12: While rst_n is low all outputs are LOW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock, one skew unit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock, synchronous to clk, used in bypass |
| range_sel | input | 2 | Three-level range select (steps per period) |
| edge_pol | input | 1 | 1: follow rising reference edge, 0: falling |
| out_stop | input | 1 | Synchronous output stop |
| test_sel | input | 2 | Three-level test select (bypass and per-bank park) |
| bank_sel | input | 16 | Two three-level selects per bank |
| q | output | 8 | Two outputs per bank, bank b on q[2b+1:2b] |

## Verification
The assertions assume that ref_in, the selects and the stop input are synchronous to the fast clock and change only between edges. The bench drives every input on the falling clock edge to satisfy this. The parking properties also assume that out_stop, edge_pol and the bank 3 selects stay stable over the two cycles they examine. The bench changes these inputs at most once per scenario and leaves long settle windows around each change. In bypass the reference is a regular square wave whose period is well above the delay-line depth, so every measured edge is unambiguous.

// File: rtl/skew_pkg.sv
`timescale 1ns/1ps
package skew_pkg;

    typedef enum logic [1:0] {
        LVL_LO  = 2'd0,
        LVL_MID = 2'd1,
        LVL_HI  = 2'd2
    } lvl_e;

    typedef enum logic [1:0] {
        MD_SKEW = 2'd0,
        MD_DIV2 = 2'd1,
        MD_DIV4 = 2'd2,
        MD_INV  = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e      mode;
        logic [4:0] skew;   // two's complement, in skew units
        logic       is_ll;
    } bank_cfg_t;

    function automatic lvl_e lvl_of(input logic [1:0] code);
        case (code)
            2'b00:   return LVL_LO;
            2'b10:   return LVL_HI;
            default: return LVL_MID;
        endcase
    endfunction

endpackage

// File: rtl/skew_phase_gen.sv
`timescale 1ns/1ps
module skew_phase_gen
    import skew_pkg::*;
#(
    parameter int STEPS_LO  = 44,
    parameter int STEPS_MID = 26,
    parameter int STEPS_HI  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] range_sel,
    input  logic       edge_pol,
    output logic       gen_o
);
    localparam int PW = $clog2(STEPS_LO);

    typedef struct packed {
        logic [PW-1:0] phase;
    } ph_t;

    ph_t           ph_d, ph_q;
    logic [PW-1:0] steps;
    logic          first_half;

    always_comb begin
        case (lvl_of(range_sel))
            LVL_LO:  steps = PW'(STEPS_LO);
            LVL_HI:  steps = PW'(STEPS_HI);
            default: steps = PW'(STEPS_MID);
        endcase
        ph_d = ph_q;
        if (ph_q.phase >= steps - PW'(1))
            ph_d.phase = '0;
        else
            ph_d.phase = ph_q.phase + PW'(1);
        first_half = ph_q.phase < (steps >> 1);
        gen_o      = ~(first_half ^ edge_pol);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q.phase < PW'(STEPS_LO)); // R2

endmodule

// File: rtl/skew_bank_decode.sv
`timescale 1ns/1ps
module skew_bank_decode
    import skew_pkg::*;
#(
    parameter int BANK = 0
) (
    input  logic [1:0] f1_i,
    input  logic [1:0] f0_i,
    output bank_cfg_t  cfg_o
);
    int idx;

    if (BANK < 2) begin : g_fine
        always_comb begin
            idx         = 3 * int'(lvl_of(f1_i)) + int'(lvl_of(f0_i));
            cfg_o       = '0;
            cfg_o.mode  = MD_SKEW;
            cfg_o.is_ll = (idx == 0);
            cfg_o.skew  = 5'(idx - 4);
        end
    end else begin : g_coarse
        always_comb begin
            idx         = 3 * int'(lvl_of(f1_i)) + int'(lvl_of(f0_i));
            cfg_o       = '0;
            cfg_o.mode  = MD_SKEW;
            cfg_o.is_ll = (idx == 0);
            if (idx == 0)
                cfg_o.mode = MD_DIV2;
            else if (idx == 8)
                cfg_o.mode = (BANK == 2) ? MD_DIV4 : MD_INV;
            else
                cfg_o.skew = 5'(2 * (idx - 4));
        end
    end

endmodule

// File: rtl/skew_clk_banks.sv
`timescale 1ns/1ps
module skew_clk_banks
    import skew_pkg::*;
#(
    parameter int STEPS_LO  = 44,
    parameter int STEPS_MID = 26,
    parameter int STEPS_HI  = 16,
    parameter int MAX_SKEW  = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_in,
    input  logic [1:0]  range_sel,
    input  logic        edge_pol,
    input  logic        out_stop,
    input  logic [1:0]  test_sel,
    input  logic [15:0] bank_sel,
    output logic [7:0]  q
);
    localparam int NBANK = 4;
    localparam int DEPTH = 2 * MAX_SKEW + 1;
    localparam int TW    = $clog2(DEPTH);
    localparam int FEED  = 2;   // bank that keeps running as feedback

    typedef struct packed {
        logic [DEPTH-1:0]   sr;
        logic [1:0]         cnt;
        logic [NBANK-1:0]   en;
        logic [2*NBANK-1:0] q;
    } st_t;

    st_t       st_d, st_q;
    bank_cfg_t cfg [NBANK];
    logic      gen;
    logic      bypass, test_mid, src, act_edge;
    logic      raw  [NBANK];
    logic      stop [NBANK];
    logic      dis  [NBANK];
    logic [TW-1:0] tap [NBANK];

    skew_phase_gen #(
        .STEPS_LO (STEPS_LO),
        .STEPS_MID(STEPS_MID),
        .STEPS_HI (STEPS_HI)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .range_sel(range_sel),
        .edge_pol (edge_pol),
        .gen_o    (gen)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_dec
        skew_bank_decode #(.BANK(g)) u_dec (
            .f1_i (bank_sel[4*g+3 -: 2]),
            .f0_i (bank_sel[4*g+1 -: 2]),
            .cfg_o(cfg[g])
        );
    end

    always_comb begin
        st_d     = st_q;
        bypass   = lvl_of(test_sel) != LVL_LO;
        test_mid = lvl_of(test_sel) == LVL_MID;
        src      = bypass ? ref_in : gen;
        st_d.sr  = {st_q.sr[DEPTH-2:0], src};
        // divider advances when the zero-skew tap is about to show the active edge
        act_edge = edge_pol ? ( st_q.sr[MAX_SKEW-1] & ~st_q.sr[MAX_SKEW])
                            : (~st_q.sr[MAX_SKEW-1] &  st_q.sr[MAX_SKEW]);
        if (act_edge) st_d.cnt = st_q.cnt + 2'd1;

        for (int b = 0; b < NBANK; b++) begin
            tap[b] = TW'(MAX_SKEW + int'($signed(cfg[b].skew)));
            case (cfg[b].mode)
                MD_DIV2: raw[b] = ~st_q.cnt[0];
                MD_DIV4: raw[b] = ~st_q.cnt[1];
                MD_INV:  raw[b] = ~st_q.sr[MAX_SKEW];
                default: raw[b] =  st_q.sr[tap[b]];
            endcase
            stop[b] = (cfg[b].mode == MD_INV) & edge_pol;
            dis[b]  = (out_stop && (b != FEED)) || (test_mid && out_stop && cfg[b].is_ll);
            if (raw[b] == stop[b]) st_d.en[b] = ~dis[b];
            st_d.q[2*b +: 2] = {2{st_q.en[b] ? raw[b] : stop[b]}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sr  <= '0;
            st_q.cnt <= '0;
            st_q.en  <= '1;
            st_q.q   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.q;

    AST_STOP_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stop && $past(out_stop) && !q[0]) |=> !q[0]); // R6

    AST_INV_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stop && $past(out_stop) && edge_pol && $past(edge_pol) &&
         cfg[3].mode == MD_INV && $stable(bank_sel) && q[6]) |=> q[6]); // R7

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != $past(st_q.cnt)) |-> (st_q.cnt == $past(st_q.cnt) + 2'd1)); // R5

    AST_RESET_LOW: assert property (@(posedge clk)
        !$past(rst_n) |-> (q == '0)); // R12

endmodule

// File: tb/skew_clk_banks_tb.sv
`timescale 1ns/1ps
module skew_clk_banks_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic [1:0]  range_sel = 2'b10;
    logic        edge_pol = 1'b1;
    logic        out_stop = 1'b0;
    logic [1:0]  test_sel = 2'b00;
    logic [15:0] bank_sel = 16'h5555;
    logic [7:0]  q;

    int checks = 0;
    int errors = 0;
    int gcyc = 0;
    int ref_per = 12;
    bit ref_en = 1'b0;
    logic [7:0] cap  [0:511];
    int         capg [0:511];

    always #10 clk = ~clk;

    skew_clk_banks u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .range_sel(range_sel),
        .edge_pol(edge_pol), .out_stop(out_stop), .test_sel(test_sel),
        .bank_sel(bank_sel), .q(q)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n, input int on_at, input int off_at);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            cap[k]  = q;
            capg[k] = gcyc;
            if (k == on_at)  out_stop = 1'b1;
            if (k == off_at) out_stop = 1'b0;
            if (ref_en) ref_in = (gcyc % ref_per) < (ref_per / 2);
            gcyc++;
        end
    endtask

    function automatic int rise_at(input int b, input int from, input int n);
        for (int k = (from < 1 ? 1 : from); k < n; k++)
            if (cap[k][b] && !cap[k-1][b]) return k;
        return -1;
    endfunction

    function automatic int high_len(input int b, input int from, input int n);
        int w = 0;
        for (int k = from; k < n && cap[k][b]; k++) w++;
        return w;
    endfunction

    function automatic logic [3:0] code_of(input int idx);
        return {2'(idx / 3), 2'(idx % 3)};
    endfunction

    task automatic set_bank(input int b, input logic [3:0] c);
        bank_sel[4*b +: 4] = c;
    endtask

    task automatic t_reset;
        run(5, -1, -1);
        for (int k = 0; k < 5; k++) chk(cap[k] == 8'h00, "R12 reset low", cap[k], 0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_range;
        logic [1:0] codes [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
        int exp [4] = '{44, 26, 16, 26};
        for (int i = 0; i < 4; i++) begin
            range_sel = codes[i];
            run(120, -1, -1);
            run(300, -1, -1);
            begin
                int r1 = rise_at(0, 1, 300);
                int r2 = rise_at(0, r1 + 1, 300);
                chk(r2 - r1 == exp[i], i == 3 ? "R1 code 11 as MID range" : "R2 period", r2 - r1, exp[i]);
                chk(high_len(0, r1, 300) == exp[i] / 2, "R2 high half", high_len(0, r1, 300), exp[i] / 2);
            end
        end
    endtask

    task automatic skew_diff(input int b, input int n, output int d);
        int rr;
        rr = rise_at(2, 20, 300);
        d  = rise_at(b, rr, 300) - rr;
    endtask

    task automatic t_codes;
        int d;
        range_sel = 2'b01; bank_sel = 16'h5555; set_bank(0, 4'b1111);
        run(60, -1, -1); run(300, -1, -1);
        skew_diff(0, 26, d);
        chk(d == 0, "R1 code 11 selects zero skew", d, 0);
    endtask

    task automatic t_skew12;
        int d, e;
        bit pair_ok;
        range_sel = 2'b01; bank_sel = 16'h5555;
        for (int i = 0; i < 9; i++) begin
            set_bank(0, code_of(i));
            run(60, -1, -1); run(300, -1, -1);
            skew_diff(0, 26, d);
            e = ((i - 4) + 26) % 26;
            chk(d == e, "R3 bank0 skew", d, e);
            pair_ok = 1'b1;
            for (int k = 0; k < 300; k++) if (cap[k][0] != cap[k][1]) pair_ok = 1'b0;
            chk(pair_ok, "R3 pair equal", pair_ok, 1);
        end
        set_bank(0, 4'b0101);
    endtask

    task automatic t_skew34;
        int d, e;
        range_sel = 2'b01; bank_sel = 16'h5555;
        for (int i = 1; i < 8; i++) begin
            set_bank(3, code_of(i));
            set_bank(2, code_of(i));
            run(60, -1, -1); run(300, -1, -1);
            skew_diff(6, 26, d);
            e = ((2 * (i - 4)) + 26) % 26;
            chk(d == e, "R4 bank3 skew", d, e);
            // bank2 compared against bank0 zero skew
            begin
                int rr = rise_at(0, 20, 300);
                int d2 = rise_at(4, rr, 300) - rr;
                chk(d2 == e, "R4 bank2 skew", d2, e);
            end
        end
        bank_sel = 16'h5555;
    endtask

    task automatic t_div;
        bit aligned;
        range_sel = 2'b10; bank_sel = 16'h5555;
        set_bank(2, 4'b1010); set_bank(3, 4'b0000);
        run(80, -1, -1); run(300, -1, -1);
        begin
            int r1 = rise_at(4, 1, 300);
            int r2 = rise_at(4, r1 + 1, 300);
            int s1 = rise_at(6, 1, 300);
            int s2 = rise_at(6, s1 + 1, 300);
            chk(r2 - r1 == 64, "R5 divide by 4 period", r2 - r1, 64);
            chk(high_len(4, r1, 300) == 32, "R5 divide by 4 high", high_len(4, r1, 300), 32);
            chk(s2 - s1 == 32, "R4 divide by 2 period", s2 - s1, 32);
            aligned = 1'b1;
            for (int k = 1; k < 300; k++)
                if (cap[k][4] && !cap[k-1][4] && !(cap[k][6] && !cap[k-1][6])) aligned = 1'b0;
            chk(aligned, "R5 divided rising edges aligned", aligned, 1);
        end
        bank_sel = 16'h5555;
    endtask

    task automatic t_inv;
        bit ok = 1'b1;
        range_sel = 2'b10; bank_sel = 16'h5555; set_bank(3, 4'b1010);
        run(40, -1, -1); run(100, -1, -1);
        for (int k = 0; k < 100; k++) if (cap[k][6] != ~cap[k][2] || cap[k][7] != cap[k][6]) ok = 1'b0;
        chk(ok, "R5 bank3 inverted", ok, 1);
        bank_sel = 16'h5555;
    endtask

    task automatic t_stop;
        int rises4 = 0;
        bit low_ok = 1'b1;
        range_sel = 2'b10; bank_sel = 16'h5555;
        run(40, -1, -1);
        run(200, 37, 123);
        for (int k = 60; k < 124; k++)
            if (cap[k][0] || cap[k][2] || cap[k][6] || cap[k][1]) low_ok = 1'b0;
        chk(low_ok, "R6 stopped banks low", low_ok, 1);
        for (int k = 61; k < 124; k++) if (cap[k][4] && !cap[k-1][4]) rises4++;
        chk(rises4 >= 2, "R6 feedback bank runs", rises4, 2);
        for (int b = 0; b < 8; b += 2)
            for (int k = 1; k < 180; k++)
                if (cap[k][b] && !cap[k-1][b]) begin
                    int w = high_len(b, k, 200);
                    if (k + w < 200) chk(w == 8, "R11 no short pulse", w, 8);
                end
    endtask

    task automatic t_inv_stop;
        bit ok = 1'b1;
        range_sel = 2'b10; bank_sel = 16'h5555; set_bank(3, 4'b1010); edge_pol = 1'b1;
        run(40, -1, -1);
        run(80, 0, -1);
        for (int k = 40; k < 80; k++) if (!cap[k][6]) ok = 1'b0;
        chk(ok, "R7 inverted parks high", ok, 1);
        edge_pol = 1'b0;
        run(80, -1, -1);
        ok = 1'b1;
        for (int k = 40; k < 80; k++) if (cap[k][6]) ok = 1'b0;
        chk(ok, "R7 inverted parks low", ok, 0 + 1);
        out_stop = 1'b0; edge_pol = 1'b1; bank_sel = 16'h5555;
        run(60, -1, -1);
    endtask

    task automatic t_ll_park;
        bit ok = 1'b1;
        int rises = 0;
        test_sel = 2'b01; ref_en = 1'b1; ref_per = 12; bank_sel = 16'h5555;
        set_bank(2, 4'b0000);
        run(40, -1, -1);
        run(80, 0, -1);
        for (int k = 40; k < 80; k++) if (cap[k][4] || cap[k][5] || cap[k][0]) ok = 1'b0;
        chk(ok, "R8 index 0 bank parked", ok, 1);
        set_bank(2, 4'b0101);
        run(80, -1, -1);
        for (int k = 41; k < 80; k++) if (cap[k][4] && !cap[k-1][4]) rises++;
        chk(rises >= 2, "R8 non-LL feedback bank runs", rises, 2);
        out_stop = 1'b0; set_bank(2, 4'b0000);
        run(60, -1, -1); run(200, -1, -1);
        begin
            int r1 = rise_at(4, 1, 200);
            int r2 = rise_at(4, r1 + 1, 200);
            chk(r2 - r1 == 24, "R8 index 0 divides without stop", r2 - r1, 24);
        end
        bank_sel = 16'h5555;
    endtask

    task automatic t_bypass;
        int r1, r2, d;
        bit lat_ok = 1'b1;
        test_sel = 2'b10; ref_en = 1'b1; ref_per = 12; bank_sel = 16'h5555;
        set_bank(1, 4'b1010);
        run(40, -1, -1); run(200, -1, -1);
        r1 = rise_at(0, 1, 200); r2 = rise_at(0, r1 + 1, 200);
        chk(r2 - r1 == 12, "R9 bypass period", r2 - r1, 12);
        chk(high_len(0, r1, 200) == 6, "R9 bypass high", high_len(0, r1, 200), 6);
        for (int k = 1; k < 200; k++)
            if (cap[k][0] && !cap[k-1][0] && ((capg[k] - 8) % 12 != 0)) lat_ok = 1'b0;
        chk(lat_ok, "R9 latency 8 cycles", lat_ok, 1);
        d = rise_at(2, r1, 200) - r1;
        chk(d == 4, "R9 skew applies in bypass", d, 4);
        bank_sel = 16'h5555;
    endtask

    task automatic t_edge;
        for (int p = 1; p >= 0; p--) begin
            bit ok = 1'b1;
            int nchg = 0;
            int e = p ? 0 : 6;
            test_sel = 2'b10; ref_en = 1'b1; ref_per = 12; edge_pol = p[0];
            bank_sel = 16'h5555; set_bank(2, 4'b0000);
            run(40, -1, -1); run(200, -1, -1);
            for (int k = 1; k < 200; k++)
                if (cap[k][4] != cap[k-1][4]) begin
                    nchg++;
                    if ((capg[k] - 8) % 12 != e) ok = 1'b0;
                end
            chk(ok && nchg > 4, p ? "R10 divided follow rising edge" : "R10 divided follow falling edge", nchg, 5);
        end
        edge_pol = 1'b1; test_sel = 2'b00; ref_en = 1'b0; bank_sel = 16'h5555;
    endtask

    initial begin
        t_reset();
        t_range();
        t_codes();
        t_skew12();
        t_skew34();
        t_div();
        t_inv();
        t_stop();
        t_inv_stop();
        t_ll_park();
        t_bypass();
        t_edge();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule